// File: doc/BRIEF.md
# Two-Level Adaptive Branch Predictor

This block tells the fetch stage, for one branch address per cycle, whether that branch should be taken and where it goes. Its main store is a set-associative target buffer. Each entry records a branch it has already seen, the branch's last resolved target and a short private history of that branch's outcomes. The history, joined with the low address bits, selects a 2-bit saturating counter in a shared pattern table. The top bit of that counter is the predicted direction.

A lookup that misses the buffer falls back to a fixed rule on the branch kind and displacement sign. When that branch later resolves, it is given an entry. Returns do not use the buffer at all: they are predicted from a small return-address stack, which calls fill and returns drain.

The lookup path is combinational from registered state. Resolutions and stack operations take effect at the next rising clock edge.

Top module: `bpred_adaptive`

## Requirements
- R1: After reset every non-return lookup misses (`pred_hit`=0). The return stack is empty, so a return lookup gives `pred_taken`=0.
- R2: On a buffer miss for a non-return lookup, `pred_taken` = `lk_uncond` OR `lk_backward`, and `pred_target` is 0.
- R3: A non-return resolution that misses the buffer allocates an entry. From the next cycle a lookup of the same address hits and returns the resolved target. The entry's history holds the outcome in bit 0 and zeros above it.
- R4: The set is taken from address bits [10:4] (16-byte lines, 128 sets). The tag carries the upper bits and the byte offset [3:0]. Up to four branches in one line therefore hold separate entries and return their own targets.
- R5: On a hit, `pred_taken` is bit 1 of the counter at index {history[3:0], address[3:0]}. The static inputs are ignored. Every counter starts at 2'b01.
- R6: A resolution that hits first steps the counter at {old history, address[3:0]}: up on taken, down on not-taken, held within 0..3. It then shifts the outcome into history bit 0.
- R7: A taken hit whose target differs from the stored one rewrites the target. A not-taken resolution leaves the stored target unchanged.
- R8: Each set uses tree pseudo-LRU replacement over 4 ways, touched by every resolution. After four allocations and a later hit on the first branch, a fifth allocation evicts the second branch.
- R9: A return lookup (`lk_ret`=1) gives `pred_hit`=0, `pred_taken` = stack non-empty, and `pred_target` = top of the stack, or 0 if the stack is empty. A resolution with `rs_ret`=1 allocates nothing.
- R10: The stack keeps the 8 newest pushes and overwrites the oldest when full. After 10 pushes, 8 pops return the newest 8 entries newest-first, and the stack is then empty.
- R11: A push and a pop in the same cycle replace the top entry and leave the depth unchanged.
- R12: A pop on an empty stack changes nothing. The next push becomes the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Branch byte address to predict |
| lk_ret | input | 1 | The branch being looked up is a return |
| lk_uncond | input | 1 | The branch being looked up is unconditional (used by the static rule) |
| lk_backward | input | 1 | The branch has a negative displacement (used by the static rule) |
| pred_hit | output | 1 | The buffer holds this branch |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted target address |
| rs_valid | input | 1 | A resolved branch is presented |
| rs_pc | input | 32 | Byte address of the resolved branch |
| rs_ret | input | 1 | The resolved branch is a return |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_target | input | 32 | Actual target of the resolved branch |
| call_push | input | 1 | Push a return address |
| call_ret_addr | input | 32 | Return address to push |
| ret_pop | input | 1 | Pop the top of the return stack |

## Verification
The one-hot hit assertion assumes the caller never allocates the same address twice without a resolution in between. The bench keeps to this by presenting each resolution on its own cycle, so every allocation is visible before the next lookup. The counter-step check assumes a resolution's address and outcome are stable over the edge that commits it. Stimulus therefore changes only at falling edges, and stack pushes and pops are driven in the same way.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  localparam logic [1:0] CTR_INIT = 2'b01;

  // saturating 2-bit counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // static fallback direction
  function automatic logic static_dir(input logic uncond, input logic backward);
    return uncond | backward;
  endfunction

  // tree pseudo-LRU over four ways: bit0 picks half, bit1 left pair, bit2 right pair
  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin n[0] = 1'b1; n[1] = (w == 2'd0); end
    else       begin n[0] = 1'b0; n[2] = (w == 2'd2); end
    return n;
  endfunction
endpackage

// File: rtl/bpred_pattern_table.sv
module bpred_pattern_table #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken
);
  import bpred_pkg::*;
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] up_rd;

  assign rd_ctr = ctr_q[rd_idx];
  assign up_rd  = ctr_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
    end else if (up_en) begin
      ctr_q[up_idx] <= ctr_step(up_rd, up_taken);
    end
  end

  // R6: a counter never wraps between its extremes
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> !(($past(up_rd) == 2'd3 && ctr_q[$past(up_idx)] == 2'd0) ||
                ($past(up_rd) == 2'd0 && ctr_q[$past(up_idx)] == 2'd3)));
endmodule

// File: rtl/bpred_target_buf.sv
module bpred_target_buf #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int HIST_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [HIST_W-1:0] lk_hist,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic              wr_taken,
  input  logic [ADDR_W-1:0] wr_target,
  output logic              rs_hit,
  output logic [HIST_W-1:0] rs_hist
);
  import bpred_pkg::*;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W;

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] pc);
    return pc[OFF_W+SET_W-1:OFF_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return {pc[ADDR_W-1:OFF_W+SET_W], pc[OFF_W-1:0]};
  endfunction

  logic              v_q    [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_q  [SETS][WAYS];
  logic [HIST_W-1:0] hist_q [SETS][WAYS];
  logic [2:0]        plru_q [SETS];

  logic [SET_W-1:0] lk_set, wr_set;
  logic [WAYS-1:0]  lk_way_hit, rs_way_hit;
  logic [WAY_W-1:0] lk_way, rs_way, victim, wr_way;
  logic             alloc_fire;

  assign lk_set = set_of(lk_pc);
  assign wr_set = set_of(wr_pc);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_way_hit[w] = v_q[lk_set][w] && (tag_q[lk_set][w] == tag_of(lk_pc));
    assign rs_way_hit[w] = v_q[wr_set][w] && (tag_q[wr_set][w] == tag_of(wr_pc));
  end

  always_comb begin
    lk_way = '0;
    rs_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_way_hit[w]) lk_way = WAY_W'(w);
      if (rs_way_hit[w]) rs_way = WAY_W'(w);
    end
  end

  assign lk_hit    = |lk_way_hit;
  assign lk_hist   = hist_q[lk_set][lk_way];
  assign lk_target = tgt_q[lk_set][lk_way];
  assign rs_hit    = |rs_way_hit;
  assign rs_hist   = hist_q[wr_set][rs_way];

  assign victim     = plru_victim(plru_q[wr_set]);
  assign wr_way     = rs_hit ? rs_way : victim;
  assign alloc_fire = wr_en && !rs_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) v_q[s][w] <= 1'b0;
      end
    end else if (wr_en) begin
      plru_q[wr_set] <= plru_touch(plru_q[wr_set], wr_way);
      if (alloc_fire) v_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (rs_hit) begin
        hist_q[wr_set][wr_way] <= {rs_hist[HIST_W-2:0], wr_taken};
        if (wr_taken && tgt_q[wr_set][wr_way] != wr_target)
          tgt_q[wr_set][wr_way] <= wr_target;
      end else begin
        tag_q[wr_set][wr_way]  <= tag_of(wr_pc);
        tgt_q[wr_set][wr_way]  <= wr_target;
        hist_q[wr_set][wr_way] <= {{(HIST_W-1){1'b0}}, wr_taken};
      end
    end
  end

  // R3: an allocation leaves a valid entry in the chosen way
  a_r3_alloc_valid: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> v_q[$past(wr_set)][$past(wr_way)]);
  // R8: replacement never lets one address occupy two ways
  a_r8_onehot_hits: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_way_hit) && $onehot0(rs_way_hit));
endmodule

// File: rtl/bpred_return_stack.sv
module bpred_return_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic              top_valid,
  output logic [ADDR_W-1:0] top_addr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              is_empty, do_push, do_repl;
  logic [PTR_W-1:0]  ptr_up;

  assign is_empty = (cnt_q == '0);
  assign do_push  = push && (!pop || is_empty);
  assign do_repl  = push && pop && !is_empty;
  assign ptr_up   = ptr_q + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (do_push) begin
      ptr_q <= ptr_up;
      if (cnt_q != FULL) cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop && !push && !is_empty) begin
      ptr_q <= ptr_q - PTR_W'(1);
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)      mem_q[ptr_up] <= push_addr;
    else if (do_repl) mem_q[ptr_q]  <= push_addr;
  end

  assign top_valid = !is_empty;
  assign top_addr  = is_empty ? '0 : mem_q[ptr_q];

  // R10: depth never exceeds the stack size
  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R12: popping an empty stack leaves it untouched
  a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && is_empty) |=> (cnt_q == '0) && $stable(ptr_q));
  // R11: push with pop keeps the depth
  a_r11_replace_depth: assert property (@(posedge clk) disable iff (!rst_n)
    do_repl |=> $stable(cnt_q));
endmodule

// File: rtl/bpred_adaptive.sv
module bpred_adaptive #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int HIST_W     = 4,
  parameter int PHT_LOW    = 4,
  parameter int RAS_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_ret,
  input  logic              lk_uncond,
  input  logic              lk_backward,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_ret,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic              call_push,
  input  logic [ADDR_W-1:0] call_ret_addr,
  input  logic              ret_pop
);
  import bpred_pkg::*;
  localparam int PHT_IDX_W = HIST_W + PHT_LOW;

  logic              tb_lk_hit, tb_rs_hit, tb_wr_en, pht_up_en;
  logic [HIST_W-1:0] tb_lk_hist, tb_rs_hist;
  logic [ADDR_W-1:0] tb_lk_target, ras_top;
  logic [1:0]        pht_ctr;
  logic              ras_valid;

  assign tb_wr_en  = rs_valid && !rs_ret;
  assign pht_up_en = tb_wr_en && tb_rs_hit;

  bpred_target_buf #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
    .LINE_BYTES(LINE_BYTES), .HIST_W(HIST_W)
  ) tbuf_i (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(tb_lk_hit), .lk_hist(tb_lk_hist), .lk_target(tb_lk_target),
    .wr_en(tb_wr_en), .wr_pc(rs_pc), .wr_taken(rs_taken), .wr_target(rs_target),
    .rs_hit(tb_rs_hit), .rs_hist(tb_rs_hist)
  );

  bpred_pattern_table #(.IDX_W(PHT_IDX_W)) pht_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx({tb_lk_hist, lk_pc[PHT_LOW-1:0]}), .rd_ctr(pht_ctr),
    .up_en(pht_up_en), .up_idx({tb_rs_hist, rs_pc[PHT_LOW-1:0]}), .up_taken(rs_taken)
  );

  bpred_return_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) ras_i (
    .clk(clk), .rst_n(rst_n),
    .push(call_push), .push_addr(call_ret_addr), .pop(ret_pop),
    .top_valid(ras_valid), .top_addr(ras_top)
  );

  always_comb begin
    if (lk_ret) begin
      pred_hit    = 1'b0;
      pred_taken  = ras_valid;
      pred_target = ras_top;
    end else if (tb_lk_hit) begin
      pred_hit    = 1'b1;
      pred_taken  = pht_ctr[1];
      pred_target = tb_lk_target;
    end else begin
      pred_hit    = 1'b0;
      pred_taken  = static_dir(lk_uncond, lk_backward);
      pred_target = '0;
    end
  end

  // R9: a return lookup never reports a buffer hit with an empty stack target
  a_r9_ret_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ret && !ras_valid) |-> (pred_target == '0) && !pred_taken);
endmodule

// File: tb/bpred_adaptive_tb_top.sv
module bpred_adaptive_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_ret = 1'b0, lk_uncond = 1'b0, lk_backward = 1'b0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target;
  logic        rs_valid = 1'b0, rs_ret = 1'b0, rs_taken = 1'b0;
  logic [31:0] rs_pc = '0, rs_target = '0;
  logic        call_push = 1'b0, ret_pop = 1'b0;
  logic [31:0] call_ret_addr = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bpred_adaptive dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_ret(lk_ret), .lk_uncond(lk_uncond), .lk_backward(lk_backward),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_ret(rs_ret), .rs_taken(rs_taken),
    .rs_target(rs_target),
    .call_push(call_push), .call_ret_addr(call_ret_addr), .ret_pop(ret_pop)
  );

  // bench-side model of the branches it drives
  logic [1:0]  m_ctr [256];
  logic [31:0] m_pc  [16];
  logic        m_v   [16];
  logic [3:0]  m_h   [16];
  logic [31:0] m_tgt [16];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic resolve(input int s, input logic tk, input logic [31:0] tg);
    @(negedge clk);
    rs_valid = 1'b1; rs_ret = 1'b0; rs_pc = m_pc[s]; rs_taken = tk; rs_target = tg;
    @(negedge clk);
    rs_valid = 1'b0;
    if (m_v[s]) begin
      m_ctr[{m_h[s], m_pc[s][3:0]}] = (tk) ?
        ((m_ctr[{m_h[s], m_pc[s][3:0]}] == 2'd3) ? 2'd3 : m_ctr[{m_h[s], m_pc[s][3:0]}] + 2'd1) :
        ((m_ctr[{m_h[s], m_pc[s][3:0]}] == 2'd0) ? 2'd0 : m_ctr[{m_h[s], m_pc[s][3:0]}] - 2'd1);
      m_h[s] = {m_h[s][2:0], tk};
      if (tk) m_tgt[s] = tg;
    end else begin
      m_v[s] = 1'b1; m_h[s] = {3'b000, tk}; m_tgt[s] = tg;
    end
  endtask

  task automatic look(input int s, input string req);
    lk_ret = 1'b0; lk_uncond = 1'b0; lk_backward = 1'b1; lk_pc = m_pc[s];
    #1;
    chk(req, {31'd0, pred_hit}, {31'd0, m_v[s]});
    if (m_v[s]) begin
      chk(req, {31'd0, pred_taken}, {31'd0, m_ctr[{m_h[s], m_pc[s][3:0]}][1]});
      chk(req, pred_target, m_tgt[s]);
    end
    lk_backward = 1'b0;
  endtask

  task automatic ras_op(input logic pu, input logic po, input logic [31:0] a);
    @(negedge clk);
    call_push = pu; ret_pop = po; call_ret_addr = a;
    @(negedge clk);
    call_push = 1'b0; ret_pop = 1'b0;
  endtask

  task automatic ras_expect(input logic v, input logic [31:0] a, input string req);
    lk_ret = 1'b1; lk_pc = 32'h0000_5550;
    #1;
    chk(req, {31'd0, pred_hit}, 32'd0);
    chk(req, {31'd0, pred_taken}, {31'd0, v});
    chk(req, pred_target, v ? a : 32'd0);
    lk_ret = 1'b0;
  endtask

  task automatic t_reset();
    lk_pc = 32'h0000_1004; #1;
    chk("R1 miss", {31'd0, pred_hit}, 32'd0);
    lk_pc = 32'hdead_beef; #1;
    chk("R1 miss", {31'd0, pred_hit}, 32'd0);
    ras_expect(1'b0, 32'd0, "R1 ras empty");
  endtask

  task automatic t_static();
    lk_ret = 1'b0; lk_pc = 32'h0000_7778;
    for (int k = 0; k < 4; k++) begin
      lk_uncond = k[0]; lk_backward = k[1]; #1;
      chk("R2 static dir", {31'd0, pred_taken}, {31'd0, k[0] | k[1]});
      chk("R2 static tgt", pred_target, 32'd0);
    end
    lk_uncond = 1'b0; lk_backward = 1'b0;
  endtask

  task automatic t_train();
    resolve(0, 1'b1, 32'h0000_2000);
    look(0, "R3 alloc");
    for (int k = 0; k < 6; k++) begin resolve(0, 1'b1, 32'h0000_2000); look(0, "R5 R6 taken run"); end
    resolve(0, 1'b0, 32'h0000_2000); look(0, "R6 not taken");
    for (int k = 0; k < 4; k++) begin resolve(0, 1'b1, 32'h0000_2000); look(0, "R6 retrain"); end
    for (int k = 0; k < 6; k++) begin resolve(0, 1'b0, 32'h0000_2000); look(0, "R6 down sat"); end
  endtask

  task automatic t_target();
    resolve(0, 1'b1, 32'h0000_3000); look(0, "R7 rewrite");
    chk("R7 rewrite", pred_target, 32'h0000_3000);
    resolve(0, 1'b0, 32'h0000_4444); look(0, "R7 keep");
    chk("R7 keep", pred_target, 32'h0000_3000);
  endtask

  task automatic t_line();
    for (int k = 1; k <= 4; k++)
      resolve(k, 1'b1, 32'h0000_a000 + 32'(k));
    for (int k = 1; k <= 4; k++) look(k, "R4 same line");
  endtask

  task automatic t_evict();
    for (int k = 8; k <= 11; k++) resolve(k, 1'b0, 32'h0000_b000 + 32'(k));
    resolve(8, 1'b0, 32'h0000_b008);
    resolve(12, 1'b1, 32'h0000_b00c);
    m_v[9] = 1'b0;
    for (int k = 8; k <= 12; k++) look(k, "R8 plru");
  endtask

  task automatic t_retres();
    @(negedge clk);
    rs_valid = 1'b1; rs_ret = 1'b1; rs_pc = m_pc[5]; rs_taken = 1'b1; rs_target = 32'h0000_0abc;
    @(negedge clk);
    rs_valid = 1'b0; rs_ret = 1'b0;
    look(5, "R9 ret no alloc");
  endtask

  task automatic t_ras();
    ras_op(1'b0, 1'b1, 32'd0);
    ras_expect(1'b0, 32'd0, "R12 empty pop");
    ras_op(1'b1, 1'b0, 32'h0000_0100);
    ras_op(1'b1, 1'b0, 32'h0000_0200);
    ras_expect(1'b1, 32'h0000_0200, "R9 ret top");
    ras_op(1'b0, 1'b1, 32'd0);
    ras_expect(1'b1, 32'h0000_0100, "R9 ret next");
    ras_op(1'b1, 1'b1, 32'h0000_0300);
    ras_expect(1'b1, 32'h0000_0300, "R11 replace");
    ras_op(1'b0, 1'b1, 32'd0);
    ras_expect(1'b0, 32'd0, "R11 depth kept");
    ras_op(1'b0, 1'b1, 32'd0);
    ras_op(1'b1, 1'b0, 32'h0000_0777);
    ras_expect(1'b1, 32'h0000_0777, "R12 push after");
    ras_op(1'b0, 1'b1, 32'd0);
    ras_expect(1'b0, 32'd0, "R12 single entry");
    for (int k = 1; k <= 10; k++) ras_op(1'b1, 1'b0, 32'(k * 16));
    for (int k = 10; k >= 3; k--) begin
      ras_expect(1'b1, 32'(k * 16), "R10 wrap order");
      ras_op(1'b0, 1'b1, 32'd0);
    end
    ras_expect(1'b0, 32'd0, "R10 drained");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_ctr[i] = 2'b01;
    for (int i = 0; i < 16; i++) begin m_v[i] = 1'b0; m_h[i] = '0; m_tgt[i] = '0; m_pc[i] = '0; end
    m_pc[0] = 32'h0000_1004;
    m_pc[1] = 32'h0000_3a41; m_pc[2] = 32'h0000_3a45;
    m_pc[3] = 32'h0000_3a49; m_pc[4] = 32'h0000_3a4e;
    m_pc[5] = 32'h0000_6608;
    for (int k = 8; k <= 12; k++) m_pc[k] = {4'(k - 7), 28'h000_0120};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_static();
    t_train();
    t_target();
    t_line();
    t_evict();
    t_retres();
    t_ras();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule